// File: doc/BRIEF.md
# Channel-List ADC Sampling Sequencer

This block drives an external successive-approximation converter from a programmed list of channel slots. Software fills up to eight slots with 3-bit channel numbers, sets the index of the last active slot, picks a per-conversion delay, and starts the engine. For each slot the sequencer waits the programmed delay, pulses a conversion request carrying the slot's channel number, and waits for the converter's done strobe. The returned sample is cut down to the configured resolution, tagged with its channel, and pushed into a 32-entry result FIFO.

A small word-addressed register interface carries the control bits, the slot list, the delay setting and a FIFO read port. The control/status word reports three busy flags: sampling busy from this block, plus averaging and delta busy inputs from neighbouring units. It also reports FIFO fill, full and empty. One pass over the list returns the engine to idle. In continuous mode it wraps to slot 0 until a stop is requested.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control/status word (address 0) reads 0x0400_0000: only the empty flag (bit 26) is set. `conv_start` is low.
- R2: A write to address 0 with bit 2 (start) set begins a run only if bit 0 (engine enable) is also 1 in the same written value. Otherwise no conversion is requested and sampling busy stays clear.
- R3: Address 1 holds slot i's channel in bits [3i+2:3i] and the last slot index in bits 26:24. A run requests slots 0 up to that index in order, with `conv_chan` equal to the slot's channel and `conv_start` high for one cycle per conversion. Without continuous mode the engine then goes idle.
- R4: A read of address 3 returns the oldest result, with the channel in bits 14:12 and the sample in bits 11:0. The sample is masked to RES_BITS bits, and all other bits are zero.
- R5: Address 2 holds a count in bits 7:0 and a unit select s in bits 9:8. Each conversion is preceded by D = (count+1)·4^s clock cycles. `conv_start` is first high D+1 cycles after the edge that accepts the start write.
- R6: With continuous mode (address 0 bit 1) set, the engine wraps from the last slot to slot 0 and keeps converting.
- R7: Writing address 0 bit 14 (stop) while busy ends the run. During a delay the engine goes idle with no further request. During a conversion it first stores that result and then goes idle. A stop while idle has no effect.
- R8: Status bits: 30 delta busy input, 29 averaging busy input, 28 sampling busy, 27 full, 26 empty, 25:21 low five bits of the fill count. This field reads 0 with full set at 32 entries.
- R9: A result arriving while the FIFO holds 32 entries, with no read in the same cycle, is dropped, and the count stays at 32.
- R10: Reading address 3 while the FIFO is empty returns 0 and leaves the count at 0.
- R11: A push and a read of a non-empty FIFO in the same cycle both take effect. The read returns the older word and the count is unchanged.
- R12: A start write while a run is in progress is ignored: the slot sequence continues without restarting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 3) |
| reg_addr | input | 2 | Word address: 0 control/status, 1 slot list, 2 delay, 3 FIFO |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from address) |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the current request |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result, valid with conv_done |
| avg_busy | input | 1 | Busy flag from the averaging unit |
| delta_busy | input | 1 | Busy flag from the delta unit |

## Verification
The converter's done strobe, which pushes a result, and a register read of the FIFO, which pops one, can land on the same clock edge. The bench waits for the done strobe to become visible, then issues the FIFO read in that very cycle while one older result is already stored. It then expects the older word on the read, a fill count still at one, and the new result on the following read. A second collision is a stop request arriving while a conversion is in flight; the bench judges it by counting stored results against issued requests.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and register addresses for the ADC sampling sequencer.
package adc_seq_pkg;
    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_REQ, SQ_CONV} sq_state_t;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LIST = 2'd1;
    localparam logic [1:0] A_DLY  = 2'd2;
    localparam logic [1:0] A_FIFO = 2'd3;
endpackage

// File: rtl/adc_seq_delay.sv
`timescale 1ns/1ps
// Delay timer: after load, expire_o rises once (cnt_i+1)*2^(UNIT_SHIFT*sel_i)
// cycles have passed. Assumes settings are stable while a delay runs.
module adc_seq_delay #(
    parameter int CNT_W      = 8,
    parameter int SEL_W      = 2,
    parameter int UNIT_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);
    localparam int PRE_W = UNIT_SHIFT * ((1 << SEL_W) - 1) + 1;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] reload;

    assign reload   = PRE_W'((1 << (UNIT_SHIFT * int'(sel_i))) - 1);
    assign expire_o = (pre_q == '0) && (cnt_q == '0);

    // Prescaler counts one unit, main counter counts units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            pre_q <= reload;
            cnt_q <= cnt_i;
        end else if (pre_q != '0) begin
            pre_q <= pre_q - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            pre_q <= reload;
        end
    end

    // R5
    delay_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && ((cnt_i != '0) || (sel_i != '0)) |=> !expire_o);
endmodule

// File: rtl/adc_seq_fifo.sv
`timescale 1ns/1ps
// Result FIFO: drops a push when full unless a pop frees space in the same
// cycle; a pop on empty is ignored and rdata_o reads zero.
module adc_seq_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rdata_o,
    output logic [$clog2(DEPTH):0]     count_o,
    output logic                       full_o,
    output logic                       empty_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          push_ok, pop_ok;

    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign pop_ok  = pop_i && !empty_o;
    assign push_ok = push_i && (!full_o || pop_ok);
    assign rdata_o = empty_o ? '0 : mem[rd_q];
    assign count_o = cnt_q;

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= wdata_i;
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i && !pop_i |=> full_o && $stable(cnt_q));
    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o && pop_i && !push_i |=> empty_o);
    // R11
    both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && pop_i && !empty_o |=> $stable(cnt_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Slot sequencer: waits the delay, requests a conversion, pushes the tagged
// result, then steps, wraps or idles. Assumes start_i is already qualified.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int CH_W     = 3,
    parameter int DATA_W   = 12,
    parameter int RES_BITS = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          stop_i,
    input  logic                          cont_i,
    input  logic [(1<<IDX_W)*CH_W-1:0]    list_i,
    input  logic [IDX_W-1:0]              max_i,
    input  logic                          expire_i,
    input  logic                          conv_done_i,
    input  logic [DATA_W-1:0]             conv_data_i,
    output logic                          load_o,
    output logic                          conv_start_o,
    output logic [CH_W-1:0]               conv_chan_o,
    output logic                          push_o,
    output logic [CH_W+DATA_W-1:0]        push_word_o,
    output logic                          busy_o
);
    localparam int SLOTS = 1 << IDX_W;
    localparam logic [DATA_W-1:0] MASK = DATA_W'((1 << RES_BITS) - 1);

    sq_state_t       st_q, st_d;
    logic [IDX_W-1:0] slot_q, slot_d;
    logic             stop_q, stop_d;
    logic [CH_W-1:0]  slot_ch [SLOTS];
    logic             last;

    // Split the packed list into per-slot channel numbers.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_ch[g] = list_i[g*CH_W +: CH_W];
    end

    assign last         = (slot_q == max_i);
    assign conv_chan_o  = slot_ch[slot_q];
    assign conv_start_o = (st_q == SQ_REQ);
    assign busy_o       = (st_q != SQ_IDLE);
    assign push_o       = (st_q == SQ_CONV) && conv_done_i;
    assign push_word_o  = {conv_chan_o, conv_data_i & MASK};

    // Next-state, slot step and pending-stop logic.
    always_comb begin
        st_d   = st_q;
        slot_d = slot_q;
        stop_d = stop_q | (stop_i && (st_q != SQ_IDLE));
        load_o = 1'b0;
        case (st_q)
            SQ_IDLE: begin
                stop_d = 1'b0;
                if (start_i) begin
                    st_d   = SQ_WAIT;
                    slot_d = '0;
                    load_o = 1'b1;
                end
            end
            SQ_WAIT: begin
                if (stop_d) begin
                    st_d   = SQ_IDLE;
                    stop_d = 1'b0;
                end else if (expire_i) begin
                    st_d = SQ_REQ;
                end
            end
            SQ_REQ: st_d = SQ_CONV;
            SQ_CONV: begin
                if (conv_done_i) begin
                    if (stop_d || (last && !cont_i)) begin
                        st_d   = SQ_IDLE;
                        stop_d = 1'b0;
                    end else begin
                        st_d   = SQ_WAIT;
                        slot_d = last ? '0 : slot_q + 1'b1;
                        load_o = 1'b1;
                    end
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            slot_q <= '0;
            stop_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            slot_q <= slot_d;
            stop_q <= stop_d;
        end
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> !busy_o);
    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !conv_done_i && !stop_i && !stop_q |=> busy_o);
    // R12
    restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !conv_done_i |=> $stable(slot_q));
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
// Top of the ADC sampling sequencer: register file, start/stop decode,
// status word and FIFO read port. Assumes one register access per cycle.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int DEPTH    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        conv_start,
    output logic [2:0]  conv_chan,
    input  logic        conv_done,
    input  logic [11:0] conv_data,
    input  logic        avg_busy,
    input  logic        delta_busy
);
    localparam int IDX_W  = 3;
    localparam int CH_W   = 3;
    localparam int DATA_W = 12;
    localparam int LIST_W = (1 << IDX_W) * CH_W;
    localparam int WORD_W = CH_W + DATA_W;
    localparam int CNT_W  = $clog2(DEPTH) + 1;

    logic              en_q, cont_q;
    logic [LIST_W-1:0] list_q;
    logic [IDX_W-1:0]  max_q;
    logic [7:0]        dcnt_q;
    logic [1:0]        dsel_q;
    logic              wr_ctrl, start, stop, pop, load, expire, push, busy;
    logic              full, empty;
    logic [WORD_W-1:0] push_word, head;
    logic [CNT_W-1:0]  count;
    logic [4:0]        count5;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign start   = wr_ctrl && reg_wdata[2] && reg_wdata[0];
    assign stop    = wr_ctrl && reg_wdata[14];
    assign pop     = reg_rd && (reg_addr == A_FIFO);
    assign count5  = count[4:0];

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            list_q <= '0;
            max_q  <= '0;
            dcnt_q <= '0;
            dsel_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    en_q   <= reg_wdata[0];
                    cont_q <= reg_wdata[1];
                end
                A_LIST: begin
                    list_q <= reg_wdata[LIST_W-1:0];
                    max_q  <= reg_wdata[26:24];
                end
                A_DLY: begin
                    dcnt_q <= reg_wdata[7:0];
                    dsel_q <= reg_wdata[9:8];
                end
                default: ;
            endcase
        end
    end

    // Read-data selection by address.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[30]    = delta_busy;
                reg_rdata[29]    = avg_busy;
                reg_rdata[28]    = busy;
                reg_rdata[27]    = full;
                reg_rdata[26]    = empty;
                reg_rdata[25:21] = count5;
                reg_rdata[1]     = cont_q;
                reg_rdata[0]     = en_q;
            end
            A_LIST: reg_rdata = {5'd0, max_q, list_q};
            A_DLY:  reg_rdata = {22'd0, dsel_q, dcnt_q};
            default: reg_rdata = {17'd0, head};
        endcase
    end

    adc_seq_delay #(.CNT_W(8), .SEL_W(2), .UNIT_SHIFT(2)) u_dly (
        .clk(clk), .rst_n(rst_n), .load_i(load), .cnt_i(dcnt_q),
        .sel_i(dsel_q), .expire_o(expire)
    );

    adc_seq_ctrl #(.IDX_W(IDX_W), .CH_W(CH_W), .DATA_W(DATA_W),
                   .RES_BITS(RES_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
        .cont_i(cont_q), .list_i(list_q), .max_i(max_q), .expire_i(expire),
        .conv_done_i(conv_done), .conv_data_i(conv_data), .load_o(load),
        .conv_start_o(conv_start), .conv_chan_o(conv_chan), .push_o(push),
        .push_word_o(push_word), .busy_o(busy)
    );

    adc_seq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(push_word),
        .pop_i(pop), .rdata_o(head), .count_o(count), .full_o(full),
        .empty_o(empty)
    );

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty |-> reg_rdata == 32'd0);
    // R8
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        conv_start, conv_done;
    logic [2:0]  conv_chan;
    logic [11:0] conv_data;
    logic        avg_busy = 1'b0, delta_busy = 1'b0;

    int checks = 0, failures = 0;
    int nstart = 0;
    int stub_lat = 3;
    logic [2:0] chan_log [64];
    logic [2:0] chan_q;
    logic       pend;
    int         lat;

    always #2.5 clk = ~clk;

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .avg_busy(avg_busy), .delta_busy(delta_busy)
    );

    // Converter stub: answers each request stub_lat+1 cycles later.
    always @(posedge clk) begin
        if (!rst_n) begin
            conv_done <= 1'b0;
            conv_data <= 12'd0;
            pend      <= 1'b0;
            lat       <= 0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                pend   <= 1'b1;
                lat    <= stub_lat;
                chan_q <= conv_chan;
                if (nstart < 64) chan_log[nstart] <= conv_chan;
                nstart <= nstart + 1;
            end else if (pend) begin
                if (lat == 0) begin
                    conv_done <= 1'b1;
                    conv_data <= {2'b11, 4'h0, chan_q, 3'b101};
                    pend      <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_word(input logic [2:0] ch);
        return {17'd0, ch, 6'd0, ch, 3'b101};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd0, s);
            if (!s[28]) break;
        end
    endtask

    task automatic drain();
        logic [31:0] s, d;
        for (int i = 0; i < 40; i++) begin
            rd(2'd0, s);
            if (s[26]) break;
            rd(2'd3, d);
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rd(2'd0, s);
        check(s == 32'h0400_0000, "R1 status after reset", s, 32'h0400_0000);
        check(conv_start == 1'b0, "R1 conv_start low", 32'(conv_start), 0);
        avg_busy = 1'b1; delta_busy = 1'b1;
        rd(2'd0, s);
        check(s[30:28] == 3'b110, "R8 busy inputs in status", 32'(s[30:28]), 32'h6);
        avg_busy = 1'b0; delta_busy = 1'b0;
    endtask

    task automatic t_no_enable();
        logic [31:0] s;
        int n0 = nstart;
        wr(2'd2, 32'd0);
        wr(2'd1, {5'd0, 3'd0, 21'd0, 3'd3});
        wr(2'd0, 32'h0000_0004);
        repeat (20) @(negedge clk);
        rd(2'd0, s);
        check(s[28] == 1'b0 && nstart == n0, "R2 start without enable",
              32'(nstart - n0), 0);
    endtask

    task automatic t_single_pass();
        logic [31:0] s, d;
        int n0 = nstart;
        wr(2'd2, 32'd0);
        wr(2'd1, {5'd0, 3'd2, 15'd0, 3'd7, 3'd2, 3'd5});
        wr(2'd0, 32'h0000_0005);
        wait_idle();
        check(nstart - n0 == 3, "R3 one pass count", 32'(nstart - n0), 3);
        check(chan_log[n0] == 3'd5 && chan_log[n0+1] == 3'd2 && chan_log[n0+2] == 3'd7,
              "R3 slot order", {chan_log[n0], chan_log[n0+1], chan_log[n0+2]}, 32'h0000_0157);
        rd(2'd0, s);
        check(s[25:21] == 5'd3 && !s[26], "R8 fill count 3", 32'(s[25:21]), 3);
        rd(2'd3, d);
        check(d == exp_word(3'd5), "R4 tagged masked word 0", d, exp_word(3'd5));
        rd(2'd3, d);
        check(d == exp_word(3'd2), "R4 tagged masked word 1", d, exp_word(3'd2));
        rd(2'd3, d);
        check(d == exp_word(3'd7), "R4 tagged masked word 2", d, exp_word(3'd7));
        rd(2'd3, d);
        check(d == 32'd0, "R10 empty read returns zero", d, 0);
        rd(2'd0, s);
        check(s[25:21] == 5'd0 && s[26], "R10 count stays zero", s, 32'h0400_0001);
    endtask

    task automatic t_delay(input logic [7:0] c, input logic [1:0] sel, input int expn);
        int n;
        wr(2'd2, {22'd0, sel, c});
        wr(2'd1, {5'd0, 3'd0, 21'd0, 3'd3});
        wr(2'd0, 32'h0000_0005);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_start && n < 2000);
        check(n == expn, "R5 delay before request", 32'(n), 32'(expn));
        wait_idle();
        drain();
    endtask

    task automatic t_cont_stop();
        logic [31:0] s;
        int n0 = nstart;
        int i;
        stub_lat = 8;
        wr(2'd2, 32'd0);
        wr(2'd1, {5'd0, 3'd1, 18'd0, 3'd0, 3'd4});
        wr(2'd0, 32'h0000_0007);
        i = 0;
        while (nstart - n0 < 1 && i < 500) begin @(negedge clk); i++; end
        wr(2'd0, 32'h0000_0007);
        i = 0;
        while (nstart - n0 < 3 && i < 500) begin @(negedge clk); i++; end
        wr(2'd0, 32'h0000_4003);
        wait_idle();
        check(nstart - n0 == 3, "R7 no request after stop", 32'(nstart - n0), 3);
        rd(2'd0, s);
        check(s[25:21] == 5'd3, "R7 in-flight result stored", 32'(s[25:21]), 3);
        check(chan_log[n0] == 3'd4 && chan_log[n0+1] == 3'd0 && chan_log[n0+2] == 3'd4,
              "R6 wrap to slot 0", {chan_log[n0], chan_log[n0+1], chan_log[n0+2]}, 32'h0000_0104);
        check(chan_log[n0+1] != 3'd4, "R12 start while busy ignored",
              32'(chan_log[n0+1]), 0);
        drain();
        stub_lat = 3;
        wr(2'd0, 32'h0000_4001);
        rd(2'd0, s);
        check(s[28] == 1'b0, "R7 stop while idle has no effect", 32'(s[28]), 0);
    endtask

    task automatic t_stop_in_delay();
        logic [31:0] s;
        int n0 = nstart;
        wr(2'd2, 32'd200);
        wr(2'd1, {5'd0, 3'd0, 21'd0, 3'd1});
        wr(2'd0, 32'h0000_0005);
        repeat (5) @(negedge clk);
        wr(2'd0, 32'h0000_4001);
        rd(2'd0, s);
        check(s[28] == 1'b0, "R7 stop during delay idles", 32'(s[28]), 0);
        repeat (250) @(negedge clk);
        check(nstart == n0, "R7 no request after stop in delay", 32'(nstart - n0), 0);
    endtask

    task automatic t_full();
        logic [31:0] s, d;
        int good;
        int n0 = nstart;
        stub_lat = 0;
        wr(2'd2, 32'd0);
        wr(2'd1, {5'd0, 3'd0, 21'd0, 3'd6});
        wr(2'd0, 32'h0000_0007);
        for (int i = 0; i < 2000; i++) begin
            rd(2'd0, s);
            if (s[27]) break;
        end
        repeat (30) @(negedge clk);
        wr(2'd0, 32'h0000_4003);
        wait_idle();
        rd(2'd0, s);
        check(s[27] && s[25:21] == 5'd0 && !s[26], "R8 full flag, count field 0",
              s, 32'h0800_0003);
        check(nstart - n0 > 33, "R9 results kept arriving while full",
              32'(nstart - n0), 34);
        good = 0;
        for (int i = 0; i < 32; i++) begin
            rd(2'd3, d);
            if (d == exp_word(3'd6)) good++;
        end
        check(good == 32, "R9 exactly 32 entries kept", 32'(good), 32);
        rd(2'd0, s);
        check(s[26] == 1'b1, "R9 empty after 32 reads", 32'(s[26]), 1);
        stub_lat = 3;
    endtask

    task automatic t_push_pop();
        logic [31:0] s, d;
        int i;
        wr(2'd2, 32'd0);
        wr(2'd1, {5'd0, 3'd0, 21'd0, 3'd6});
        wr(2'd0, 32'h0000_0005);
        wait_idle();
        wr(2'd1, {5'd0, 3'd0, 21'd0, 3'd1});
        wr(2'd0, 32'h0000_0005);
        i = 0;
        do begin @(negedge clk); i++; end while (!conv_done && i < 500);
        reg_rd = 1'b1; reg_addr = 2'd3;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        check(d == exp_word(3'd6), "R11 same-cycle read gets older word", d, exp_word(3'd6));
        rd(2'd0, s);
        check(s[25:21] == 5'd1, "R11 count unchanged", 32'(s[25:21]), 1);
        rd(2'd3, d);
        check(d == exp_word(3'd1), "R11 new word kept", d, exp_word(3'd1));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_enable();
        t_single_pass();
        t_delay(8'd3, 2'd1, 17);
        t_delay(8'd5, 2'd0, 7);
        t_cont_stop();
        t_stop_in_delay();
        t_full();
        t_push_pop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule